// File: doc/BRIEF.md
# Parallel Move Legality Checker

This block screens one decoded instruction that pairs a data-ALU operation with two parallel data moves and reports whether the combination is allowed. The first move either transfers one word between X memory and a register, in one direction or the other, or loads an immediate value taken from an extension word into a register. The second move always copies one register into another. The decoder presents the ALU opcode class, the ALU source and destination register portions, and the type, direction and registers of each move. The checker returns a legal flag and a separate flag for each reason an instruction can fail.

A register portion is named by a register index and a portion field. Two names refer to the same storage only when both parts match. The block checks that the data type of the opcode and the data types of both moves agree. It rejects any register portion that two parties try to write in the same instruction. Several parties may read the same portion freely. With the parameter `PIPE` set, all outputs pass through one register stage that a synchronous reset clears. With `PIPE` cleared, the outputs follow the inputs combinationally.

Top module: `pmove_legality_chk`

## Requirements
- R1: When move 1 is a store (`mv1_store`=1, `mv1_imm`=0, register to memory), its register is only read, so a match between that register and any destination raises no flag.
- R2: An immediate load (`mv1_imm`=1) writes the move-1 register in the same way as a memory load, and `mv1_store` is ignored while `mv1_imm` is 1.
- R3: With an integer opcode (`alu_float`=0), `type_err` is 1 when either move is a floating-point move (`mv*_float`=1), and 0 when both are integer moves.
- R4: With a floating-point opcode (`alu_float`=1), `type_err` is 1 when either move is an integer move (`mv*_float`=0), and 0 when both are floating-point moves.
- R5: When the ALU writes (`alu_wr`=1), `alu_dup_err` is 1 if the ALU destination equals the destination of move 2 or of a writing move 1. When `alu_wr`=0, `alu_dup_err` is 0.
- R6: An ALU source or destination that is also a move source (the store register of move 1, or the source of move 2) raises no flag.
- R7: `move_dup_err` is 1 when move 1 writes its register and that register equals the destination of move 2.
- R8: Register portions collide only when both the 3-bit index and the 2-bit portion field are equal. A match in only one of the two raises no flag.
- R9: `legal` is 1 exactly when `type_err`, `alu_dup_err` and `move_dup_err` are all 0. Several flags may be 1 together.
- R10: With `PIPE`=1, every output reflects the inputs of the previous clock edge, and a synchronous `rst` drives all four outputs to 0. With `PIPE`=0, the outputs follow the present inputs and `rst` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| alu_float | input | 1 | Opcode class: 1 = floating-point, 0 = integer |
| alu_wr | input | 1 | ALU operation writes its destination |
| alu_dst_idx | input | IDX_W | ALU destination register index |
| alu_dst_part | input | PART_W | ALU destination portion field |
| alu_src_idx | input | IDX_W | ALU source register index |
| alu_src_part | input | PART_W | ALU source portion field |
| mv1_float | input | 1 | Move 1 type: 1 = floating-point, 0 = integer |
| mv1_store | input | 1 | Move 1 direction: 1 = register to memory, 0 = memory to register |
| mv1_imm | input | 1 | Move 1 loads an immediate from the extension word |
| mv1_reg_idx | input | IDX_W | Move 1 register index |
| mv1_reg_part | input | PART_W | Move 1 portion field |
| mv2_float | input | 1 | Move 2 type: 1 = floating-point, 0 = integer |
| mv2_src_idx | input | IDX_W | Move 2 source register index |
| mv2_src_part | input | PART_W | Move 2 source portion field |
| mv2_dst_idx | input | IDX_W | Move 2 destination register index |
| mv2_dst_part | input | PART_W | Move 2 destination portion field |
| legal | output | 1 | Instruction passes every check |
| type_err | output | 1 | Opcode and move types disagree |
| alu_dup_err | output | 1 | ALU destination also written by a move |
| move_dup_err | output | 1 | Both moves write the same portion |

## Verification
The assertions sample the inputs only at rising clock edges. They assume the decoder holds each instruction's fields steady across that edge and that no field is unknown. The bench changes inputs only on falling edges and drives every field from a fully specified vector. The pipelined properties also assume one instruction per cycle with no stall, which the stimulus loop provides by presenting a new vector every cycle.

// File: rtl/pmove_legality_chk.sv
module pmove_legality_chk #(
  parameter int IDX_W  = 3,
  parameter int PART_W = 2,
  parameter bit PIPE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alu_float,
  input  logic              alu_wr,
  input  logic [IDX_W-1:0]  alu_dst_idx,
  input  logic [PART_W-1:0] alu_dst_part,
  input  logic [IDX_W-1:0]  alu_src_idx,
  input  logic [PART_W-1:0] alu_src_part,
  input  logic              mv1_float,
  input  logic              mv1_store,
  input  logic              mv1_imm,
  input  logic [IDX_W-1:0]  mv1_reg_idx,
  input  logic [PART_W-1:0] mv1_reg_part,
  input  logic              mv2_float,
  input  logic [IDX_W-1:0]  mv2_src_idx,
  input  logic [PART_W-1:0] mv2_src_part,
  input  logic [IDX_W-1:0]  mv2_dst_idx,
  input  logic [PART_W-1:0] mv2_dst_part,
  output logic              legal,
  output logic              type_err,
  output logic              alu_dup_err,
  output logic              move_dup_err
);
  localparam int SEL_W = IDX_W + PART_W;

  logic [SEL_W-1:0] alu_dst, mv1_reg, mv2_dst;
  logic mv1_writes, type_c, alu_dup_c, mv_dup_c, legal_c;

  assign alu_dst = {alu_dst_idx, alu_dst_part};
  assign mv1_reg = {mv1_reg_idx, mv1_reg_part};
  assign mv2_dst = {mv2_dst_idx, mv2_dst_part};

  // a store only reads its register; loads and immediates write it
  assign mv1_writes = mv1_imm | ~mv1_store;

  assign type_c    = alu_float ? ~(mv1_float & mv2_float) : (mv1_float | mv2_float);
  assign alu_dup_c = alu_wr & ((mv1_writes & (alu_dst == mv1_reg)) | (alu_dst == mv2_dst));
  assign mv_dup_c  = mv1_writes & (mv1_reg == mv2_dst);
  assign legal_c   = ~(type_c | alu_dup_c | mv_dup_c);

  // sources never take part in a check: reads may be shared
  logic unused_sources;
  assign unused_sources = ^{alu_src_idx, alu_src_part, mv2_src_idx, mv2_src_part};

  generate
    if (PIPE) begin : g_pipe
      always_ff @(posedge clk) begin
        if (rst) begin
          legal        <= 1'b0;
          type_err     <= 1'b0;
          alu_dup_err  <= 1'b0;
          move_dup_err <= 1'b0;
        end else begin
          legal        <= legal_c;
          type_err     <= type_c;
          alu_dup_err  <= alu_dup_c;
          move_dup_err <= mv_dup_c;
        end
      end

      a_r3_int_moves_ok: assert property (@(posedge clk) disable iff (rst)
        (!alu_float && !mv1_float && !mv2_float) |=> !type_err);
      a_r4_float_needs_float: assert property (@(posedge clk) disable iff (rst)
        (alu_float && !(mv1_float && mv2_float)) |=> type_err);
      a_r5_no_write_no_dup: assert property (@(posedge clk) disable iff (rst)
        !alu_wr |=> !alu_dup_err);
      a_r1_store_never_dups: assert property (@(posedge clk) disable iff (rst)
        (mv1_store && !mv1_imm) |=> !move_dup_err);
      a_r9_legal_excl: assert property (@(posedge clk) disable iff (rst)
        (alu_float != mv2_float) |=> !legal);
    end else begin : g_comb
      assign legal        = legal_c;
      assign type_err     = type_c;
      assign alu_dup_err  = alu_dup_c;
      assign move_dup_err = mv_dup_c;

      logic unused_clocking;
      assign unused_clocking = clk ^ rst;

      a_r3_int_moves_ok: assert property (@(posedge clk) disable iff (rst)
        (!alu_float && !mv1_float && !mv2_float) |-> !type_err);
      a_r4_float_needs_float: assert property (@(posedge clk) disable iff (rst)
        (alu_float && !(mv1_float && mv2_float)) |-> type_err);
      a_r5_no_write_no_dup: assert property (@(posedge clk) disable iff (rst)
        !alu_wr |-> !alu_dup_err);
      a_r1_store_never_dups: assert property (@(posedge clk) disable iff (rst)
        (mv1_store && !mv1_imm) |-> !move_dup_err);
      a_r9_legal_excl: assert property (@(posedge clk) disable iff (rst)
        (alu_float != mv2_float) |-> !legal);
    end
  endgenerate
endmodule

// File: tb/pmove_legality_chk_test.sv
module pmove_legality_chk_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       alu_float, alu_wr, mv1_float, mv1_store, mv1_imm, mv2_float;
  logic [2:0] alu_dst_idx, alu_src_idx, mv1_reg_idx, mv2_src_idx, mv2_dst_idx;
  logic [1:0] alu_dst_part, alu_src_part, mv1_reg_part, mv2_src_part, mv2_dst_part;
  logic       p_legal, p_type, p_adup, p_mdup;
  logic       c_legal, c_type, c_adup, c_mdup;

  pmove_legality_chk #(.IDX_W(3), .PART_W(2), .PIPE(1'b1)) uut (
    .clk(clk), .rst(rst), .alu_float(alu_float), .alu_wr(alu_wr),
    .alu_dst_idx(alu_dst_idx), .alu_dst_part(alu_dst_part),
    .alu_src_idx(alu_src_idx), .alu_src_part(alu_src_part),
    .mv1_float(mv1_float), .mv1_store(mv1_store), .mv1_imm(mv1_imm),
    .mv1_reg_idx(mv1_reg_idx), .mv1_reg_part(mv1_reg_part),
    .mv2_float(mv2_float), .mv2_src_idx(mv2_src_idx), .mv2_src_part(mv2_src_part),
    .mv2_dst_idx(mv2_dst_idx), .mv2_dst_part(mv2_dst_part),
    .legal(p_legal), .type_err(p_type), .alu_dup_err(p_adup), .move_dup_err(p_mdup));

  pmove_legality_chk #(.IDX_W(3), .PART_W(2), .PIPE(1'b0)) uut_comb (
    .clk(clk), .rst(rst), .alu_float(alu_float), .alu_wr(alu_wr),
    .alu_dst_idx(alu_dst_idx), .alu_dst_part(alu_dst_part),
    .alu_src_idx(alu_src_idx), .alu_src_part(alu_src_part),
    .mv1_float(mv1_float), .mv1_store(mv1_store), .mv1_imm(mv1_imm),
    .mv1_reg_idx(mv1_reg_idx), .mv1_reg_part(mv1_reg_part),
    .mv2_float(mv2_float), .mv2_src_idx(mv2_src_idx), .mv2_src_part(mv2_src_part),
    .mv2_dst_idx(mv2_dst_idx), .mv2_dst_part(mv2_dst_part),
    .legal(c_legal), .type_err(c_type), .alu_dup_err(c_adup), .move_dup_err(c_mdup));

  // layout: af aw adst[5] asrc[5] m1f m1st m1imm m1reg[5] m2f m2src[5] m2dst[5] | legal type adup mdup
  // register names are {idx,part}: 4={1,0} 5={1,1} 6={1,2} 8={2,0} 12={3,0} 18={4,2} 21={5,1}
  localparam int NV = 17;
  localparam logic [34:0] VECS [NV] = '{
    {1'b0,1'b1,5'd4,5'd8,1'b0,1'b0,1'b0,5'd12,1'b0,5'd18,5'd21,4'b1000}, // R9 integer, legal
    {1'b1,1'b1,5'd4,5'd8,1'b1,1'b0,1'b0,5'd12,1'b1,5'd18,5'd21,4'b1000}, // R9 float, legal
    {1'b0,1'b1,5'd4,5'd8,1'b0,1'b0,1'b0,5'd12,1'b1,5'd18,5'd21,4'b0100}, // R3 move 2 float
    {1'b0,1'b1,5'd4,5'd8,1'b1,1'b0,1'b0,5'd12,1'b0,5'd18,5'd21,4'b0100}, // R3 move 1 float
    {1'b1,1'b1,5'd4,5'd8,1'b0,1'b0,1'b0,5'd12,1'b1,5'd18,5'd21,4'b0100}, // R4 move 1 integer
    {1'b1,1'b1,5'd4,5'd8,1'b0,1'b0,1'b0,5'd12,1'b0,5'd18,5'd21,4'b0100}, // R4 both integer
    {1'b0,1'b1,5'd4,5'd8,1'b0,1'b0,1'b0,5'd4 ,1'b0,5'd18,5'd21,4'b0010}, // R5 load hits ALU dst
    {1'b0,1'b1,5'd4,5'd8,1'b0,1'b0,1'b0,5'd12,1'b0,5'd18,5'd4 ,4'b0010}, // R5 move 2 hits ALU dst
    {1'b0,1'b0,5'd4,5'd8,1'b0,1'b0,1'b0,5'd12,1'b0,5'd18,5'd4 ,4'b1000}, // R5 ALU not writing
    {1'b0,1'b1,5'd4,5'd8,1'b0,1'b1,1'b0,5'd4 ,1'b0,5'd18,5'd21,4'b1000}, // R1 store reads ALU dst
    {1'b0,1'b1,5'd4,5'd8,1'b0,1'b1,1'b1,5'd4 ,1'b0,5'd18,5'd21,4'b0010}, // R2 immediate writes
    {1'b0,1'b1,5'd4,5'd8,1'b0,1'b1,1'b0,5'd8 ,1'b0,5'd4 ,5'd21,4'b1000}, // R6 shared reads
    {1'b0,1'b1,5'd4,5'd8,1'b0,1'b0,1'b0,5'd21,1'b0,5'd18,5'd21,4'b0001}, // R7 moves collide
    {1'b0,1'b1,5'd4,5'd8,1'b0,1'b1,1'b0,5'd21,1'b0,5'd18,5'd21,4'b1000}, // R7 R1 store no collide
    {1'b0,1'b1,5'd4,5'd8,1'b0,1'b0,1'b0,5'd6 ,1'b0,5'd18,5'd5 ,4'b1000}, // R8 same idx, other part
    {1'b0,1'b1,5'd4,5'd8,1'b0,1'b0,1'b0,5'd12,1'b0,5'd18,5'd8 ,4'b1000}, // R8 same part, other idx
    {1'b1,1'b1,5'd4,5'd8,1'b0,1'b0,1'b0,5'd4 ,1'b1,5'd18,5'd4 ,4'b0111}  // R9 all flags together
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b (legal,type,adup,mdup)", req, got, exp);
    end
  endtask

  task automatic apply(input logic [34:0] v);
    {alu_float, alu_wr, alu_dst_idx, alu_dst_part, alu_src_idx, alu_src_part,
     mv1_float, mv1_store, mv1_imm, mv1_reg_idx, mv1_reg_part,
     mv2_float, mv2_src_idx, mv2_src_part, mv2_dst_idx, mv2_dst_part} = v[34:4];
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    apply(VECS[0]);
    repeat (3) @(negedge clk);
    // R10 reset clears the pipelined outputs even with a legal instruction present
    check("R10 reset clears pipe", {p_legal, p_type, p_adup, p_mdup}, 4'b0000);
    // R10 combinational variant ignores reset
    check("R10 comb ignores reset", {c_legal, c_type, c_adup, c_mdup}, 4'b1000);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      #1;
      check($sformatf("R10 comb vector %0d", i), {c_legal, c_type, c_adup, c_mdup}, VECS[i][3:0]);
      @(negedge clk);
      check($sformatf("R10 pipe vector %0d", i), {p_legal, p_type, p_adup, p_mdup}, VECS[i][3:0]);
    end
    // R10 pipe holds the previous cycle's result until the next edge
    apply(VECS[2]);
    #1;
    check("R10 pipe delay", {p_legal, p_type, p_adup, p_mdup}, VECS[NV-1][3:0]);
    @(negedge clk);
    check("R3 after delay", {p_legal, p_type, p_adup, p_mdup}, 4'b0100);
    // R10 mid-run reset clears an error result
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid reset", {p_legal, p_type, p_adup, p_mdup}, 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    check("R10 after reset", {p_legal, p_type, p_adup, p_mdup}, 4'b0100);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule